// File: doc/BRIEF.md
# Interval Program Sequencer Clock

This block is a program clock. It steps through the timed intervals of one of several stored programs. Each program has its own number of intervals, and each interval has a duration and a binary output pattern. A one-hot selection input picks the program. Four plain control pins drive the clock:

- a start pin, acting on its rising edge;
- a stop pin, acting on its level;
- a clear pin, acting on its rising edge;
- a fast pin, acting on its level.

The block reports the current interval, the time elapsed inside that interval, the output pattern of that interval, a halted flag and a blink enable for an indicator lamp.

Time is counted in base ticks. A free-running prescaler makes one tick every `PRESCALE` clock cycles. In fast mode each tick adds a programmable acceleration factor instead of one. Durations, patterns, interval counts and the acceleration factor are loaded through a simple write strobe. Any write restarts the clock from its origin.

A retain input chooses what power-up means. When it is low, the synchronous reset puts the clock at its origin. When it is high, all clock state survives the reset and a running program carries on.

There is no data stream through the block, so every pin is a plain level or strobe. None of them uses a valid/ready handshake.

Top module: `ipc_program_clock`

## Requirements
- R1: While `rst_n` is low and `retain_i` is low, the block sets interval 0, elapsed 0 and pattern 0, stops the clock and sets the blink state. The next start then begins from the origin.
- R2: While `rst_n` is low and `retain_i` is high, interval, elapsed time, pattern, run state and latched program all keep their values. A program that was running continues after `rst_n` returns high.
- R3: A rising edge on `start_i` sets the clock running when all of these hold: stop is low, the clock is not running, `sel_i` has exactly one bit set, and that program's interval count is nonzero. If the clock is at its origin, the program `k` of bit `k` is latched and the outputs show interval 0, elapsed 0 and the first pattern of that program.
- R4: A start edge after a stop resumes the latched program from the interval and elapsed time that were held. It does not return to the origin.
- R5: A start edge is refused, and the clock stays halted, when `sel_i` is all zero, when `sel_i` has more than one bit set, or when the selected program has zero intervals.
- R6: While `stop_i` is high:
  - elapsed time and interval do not change;
  - the pattern holds;
  - `halted_o` is high;
  - start edges are ignored;
  - the clock stops running, so a new start edge is needed after stop falls.
- R7: A rising edge on `clr_i` acts whatever the level of `stop_i`. At the next edge the clock shows interval 0, elapsed 0, halted, and the first pattern of the selected program (program 0 if the selection is not one-hot). Blink is set until a start is accepted. If start and clear edges arrive in the same cycle, the clear wins.
- R8: The base tick comes every `PRESCALE` clock cycles. The first tick comes in the `PRESCALE`-th cycle after reset is released. Time advances only on a tick.
- R9: On each tick while running, elapsed time grows by 1 when `fast_i` is low. When `fast_i` is high it grows by the acceleration factor, and a factor of 0 counts as 1.
- R10: When elapsed time plus the increment reaches or passes the current interval's duration and a further interval exists, the clock moves to the next interval. Elapsed time returns to 0, any excess is discarded, and the pattern of the new interval is shown. A zero duration is left on the first tick.
- R11: When the last interval ends, the clock halts and elapsed time shows that interval's duration. The pattern holds, blink stays low, and the next accepted start begins from the origin.
- R12: Configuration writes use `cfg_kind_i`:
  - 0 writes a duration;
  - 1 writes a pattern (the low `OW` bits);
  - 2 writes a program's interval count, clamped to `NINT`;
  - 3 writes the acceleration factor.
  One cycle after any write, the clock is put back to its origin exactly as in R7, using the new contents.
- R13: `halted_o` is high when the clock is not running or `stop_i` is high. `blink_o` is high when `stop_i` is high or the clock is held after a clear, configuration or power-up origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| retain_i | input | 1 | High keeps clock state through reset |
| start_i | input | 1 | Start / resume, acts on its rising edge |
| stop_i | input | 1 | Stop level |
| clr_i | input | 1 | Clear to origin, acts on its rising edge |
| fast_i | input | 1 | Accelerated time base level |
| sel_i | input | NPROG | One-hot program selection |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 2 | Write target: 0 duration, 1 pattern, 2 count, 3 factor |
| cfg_prog_i | input | PW | Program addressed by the write |
| cfg_idx_i | input | IW | Interval addressed by the write |
| cfg_wdata_i | input | TW | Write data |
| ivl_o | output | IW | Current interval index, 0 based |
| elapsed_o | output | TW | Elapsed time inside the interval |
| pattern_o | output | OW | Binary outputs of the current interval |
| halted_o | output | 1 | Clock is not advancing |
| blink_o | output | 1 | Indicator blink enable |

## Verification
Several control actions can fall on the same clock edge:
- a clear edge and a start edge;
- a stop level and a base tick;
- a configuration-triggered clear and a running tick.

The bench provokes the first by raising `start_i` and `clr_i` on the same falling edge while the clock is running. The others arise naturally because ticks keep running under stop and during configuration writes. A behavioural model applies the priority order clear, then stop, then start, then advance, and its five outputs are compared with the design after every edge.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    CFG_DUR = 2'd0,
    CFG_PAT = 2'd1,
    CFG_CNT = 2'd2,
    CFG_ACC = 2'd3
  } cfg_kind_t;
endpackage

// File: rtl/ipc_tick_gen.sv
module ipc_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int SW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  logic [SW-1:0] cnt_q;

  assign tick_o = (cnt_q == SW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + SW'(1);
  end
endmodule

// File: rtl/ipc_edge_det.sv
module ipc_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end
endmodule

// File: rtl/ipc_cfg_store.sv
module ipc_cfg_store
  import ipc_pkg::*;
#(
  parameter int NPROG = 4,
  parameter int NINT  = 8,
  parameter int TW    = 16,
  parameter int OW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [1:0]    kind_i,
  input  logic [((NPROG > 1) ? $clog2(NPROG) : 1)-1:0] wprog_i,
  input  logic [((NINT > 1) ? $clog2(NINT) : 1)-1:0]   widx_i,
  input  logic [TW-1:0] wdata_i,
  input  logic [((NPROG > 1) ? $clog2(NPROG) : 1)-1:0] cur_prog_i,
  input  logic [((NINT > 1) ? $clog2(NINT) : 1)-1:0]   cur_ivl_i,
  input  logic [((NINT > 1) ? $clog2(NINT) : 1)-1:0]   nxt_ivl_i,
  input  logic [((NPROG > 1) ? $clog2(NPROG) : 1)-1:0] first_prog_i,
  output logic [TW-1:0] dur_cur_o,
  output logic [OW-1:0] pat_nxt_o,
  output logic [OW-1:0] pat_first_o,
  output logic [$clog2(NINT+1)-1:0] cnt_cur_o,
  output logic [$clog2(NINT+1)-1:0] cnt_first_o,
  output logic [TW-1:0] accel_o,
  output logic          chg_o
);
  localparam int CW = $clog2(NINT + 1);

  logic [TW-1:0] dur_mem [NPROG][NINT];
  logic [OW-1:0] pat_mem [NPROG][NINT];
  logic [CW-1:0] cnt_mem [NPROG];
  logic [TW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (we_i && (int'(wprog_i) < NPROG) && (int'(widx_i) < NINT)) begin
      case (cfg_kind_t'(kind_i))
        CFG_DUR: dur_mem[wprog_i][widx_i] <= wdata_i;
        CFG_PAT: pat_mem[wprog_i][widx_i] <= wdata_i[OW-1:0];
        CFG_CNT: cnt_mem[wprog_i] <= (wdata_i > TW'(NINT)) ? CW'(NINT) : CW'(wdata_i);
        default: acc_q <= wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg_o <= 1'b0;
    else        chg_o <= we_i;
  end

  assign dur_cur_o   = dur_mem[cur_prog_i][cur_ivl_i];
  assign pat_nxt_o   = pat_mem[cur_prog_i][nxt_ivl_i];
  assign pat_first_o = pat_mem[first_prog_i][0];
  assign cnt_cur_o   = cnt_mem[cur_prog_i];
  assign cnt_first_o = cnt_mem[first_prog_i];
  assign accel_o     = (acc_q == '0) ? TW'(1) : acc_q;
endmodule

// File: rtl/ipc_program_clock.sv
module ipc_program_clock
  import ipc_pkg::*;
#(
  parameter int NPROG    = 4,
  parameter int NINT     = 8,
  parameter int TW       = 16,
  parameter int OW       = 8,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retain_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          clr_i,
  input  logic          fast_i,
  input  logic [NPROG-1:0] sel_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_kind_i,
  input  logic [((NPROG > 1) ? $clog2(NPROG) : 1)-1:0] cfg_prog_i,
  input  logic [((NINT > 1) ? $clog2(NINT) : 1)-1:0]   cfg_idx_i,
  input  logic [TW-1:0] cfg_wdata_i,
  output logic [((NINT > 1) ? $clog2(NINT) : 1)-1:0]   ivl_o,
  output logic [TW-1:0] elapsed_o,
  output logic [OW-1:0] pattern_o,
  output logic          halted_o,
  output logic          blink_o
);
  localparam int PW = (NPROG > 1) ? $clog2(NPROG) : 1;
  localparam int IW = (NINT > 1) ? $clog2(NINT) : 1;
  localparam int CW = $clog2(NINT + 1);

  logic [IW-1:0] ivl_q, ivl_nxt;
  logic [TW-1:0] time_q;
  logic [OW-1:0] pat_q;
  logic [PW-1:0] prog_q, sel_idx, first_prog;
  logic          run_q, origin_q, hold_q;
  logic          tick, cfg_chg, sel_ok, last_ivl;
  logic [1:0]    rises;
  logic          st_edge, clr_edge;
  logic [TW-1:0] dur_cur, accel, inc;
  logic [TW:0]   sum;
  logic [OW-1:0] pat_nxt, pat_first;
  logic [CW-1:0] cnt_cur, cnt_first;

  ipc_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  ipc_edge_det #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl_i({clr_i, start_i}), .rise_o(rises)
  );
  assign st_edge  = rises[0];
  assign clr_edge = rises[1];

  ipc_cfg_store #(.NPROG(NPROG), .NINT(NINT), .TW(TW), .OW(OW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .kind_i(cfg_kind_i),
    .wprog_i(cfg_prog_i), .widx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .cur_prog_i(prog_q), .cur_ivl_i(ivl_q), .nxt_ivl_i(ivl_nxt),
    .first_prog_i(first_prog), .dur_cur_o(dur_cur), .pat_nxt_o(pat_nxt),
    .pat_first_o(pat_first), .cnt_cur_o(cnt_cur), .cnt_first_o(cnt_first),
    .accel_o(accel), .chg_o(cfg_chg)
  );

  always_comb begin
    sel_ok  = $onehot(sel_i);
    sel_idx = '0;
    for (int k = 0; k < NPROG; k++) begin
      if (sel_i[k]) sel_idx = PW'(k);
    end
    first_prog = sel_ok ? sel_idx : '0;
    ivl_nxt    = (int'(ivl_q) == NINT - 1) ? '0 : ivl_q + IW'(1);
    last_ivl   = (CW'(ivl_q) + CW'(1)) >= cnt_cur;
    inc        = fast_i ? accel : TW'(1);
    sum        = {1'b0, time_q} + {1'b0, inc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (!retain_i) begin
        ivl_q    <= '0;
        time_q   <= '0;
        pat_q    <= '0;
        prog_q   <= '0;
        run_q    <= 1'b0;
        origin_q <= 1'b1;
        hold_q   <= 1'b1;
      end
    end else if (cfg_chg || clr_edge) begin
      ivl_q    <= '0;
      time_q   <= '0;
      pat_q    <= pat_first;
      prog_q   <= first_prog;
      run_q    <= 1'b0;
      origin_q <= 1'b1;
      hold_q   <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (st_edge && !run_q && sel_ok && (cnt_first != '0)) begin
      run_q    <= 1'b1;
      origin_q <= 1'b0;
      hold_q   <= 1'b0;
      if (origin_q) begin
        ivl_q  <= '0;
        time_q <= '0;
        pat_q  <= pat_first;
        prog_q <= first_prog;
      end
    end else if (run_q && tick) begin
      if (sum >= {1'b0, dur_cur}) begin
        if (!last_ivl) begin
          ivl_q  <= ivl_nxt;
          time_q <= '0;
          pat_q  <= pat_nxt;
        end else begin
          run_q    <= 1'b0;
          origin_q <= 1'b1;
          time_q   <= dur_cur;
        end
      end else begin
        time_q <= sum[TW-1:0];
      end
    end
  end

  assign ivl_o     = ivl_q;
  assign elapsed_o = time_q;
  assign pattern_o = pat_q;
  assign halted_o  = !run_q || stop_i;
  assign blink_o   = stop_i || hold_q;

  assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !clr_edge && !cfg_chg) |=> ($stable(time_q) && $stable(ivl_q) && $stable(pat_q) && !run_q));

  assert_clear_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_edge |=> (ivl_q == '0 && time_q == '0 && !run_q && blink_o));

  assert_refuse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_edge && !$onehot(sel_i) && !run_q) |=> !run_q);

  assert_ivl_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cfg_chg) |-> (CW'(ivl_q) < cnt_cur));

  assert_finish_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !stop_i && !clr_edge && !cfg_chg && last_ivl && sum >= {1'b0, dur_cur})
      |=> (!run_q && !blink_o));
endmodule

// File: tb/sim_ipc_program_clock.sv
module sim_ipc_program_clock;
  localparam int NPROG = 4, NINT = 8, TW = 16, OW = 8, PRE = 4;

  logic clk = 0, rst_n = 0, retain = 0, start = 0, stop = 0, clr = 0, fast = 0;
  logic [NPROG-1:0] sel = 4'b0001;
  logic cfg_we = 0;
  logic [1:0] cfg_kind = 0;
  logic [1:0] cfg_prog = 0;
  logic [2:0] cfg_idx = 0;
  logic [TW-1:0] cfg_wdata = 0;
  logic [2:0] ivl;
  logic [TW-1:0] elapsed;
  logic [OW-1:0] pattern;
  logic halted, blink;

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  ipc_program_clock #(.NPROG(NPROG), .NINT(NINT), .TW(TW), .OW(OW), .PRESCALE(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .retain_i(retain), .start_i(start), .stop_i(stop),
    .clr_i(clr), .fast_i(fast), .sel_i(sel), .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind),
    .cfg_prog_i(cfg_prog), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .ivl_o(ivl), .elapsed_o(elapsed), .pattern_o(pattern), .halted_o(halted), .blink_o(blink)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_dur[NPROG][NINT], m_pat[NPROG][NINT], m_cnt[NPROG], m_acc;
  int m_ivl, m_time, m_pat_o, m_prog, m_pre;
  bit m_run, m_origin = 1, m_hold = 1, m_ps, m_pc, m_chg;

  task automatic expect_eq(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_pc = 0; m_pre = 0; m_chg = 0;
      if (!retain) begin
        m_ivl = 0; m_time = 0; m_pat_o = 0; m_prog = 0;
        m_run = 0; m_origin = 1; m_hold = 1;
      end
    end else begin
      bit tk, se, ce, ok;
      int idx, inc;
      tk = (m_pre == PRE - 1);
      m_pre = tk ? 0 : m_pre + 1;
      se = start && !m_ps; ce = clr && !m_pc;
      m_ps = start; m_pc = clr;
      ok = ($countones(sel) == 1);
      idx = 0;
      for (int k = 0; k < NPROG; k++) if (sel[k]) idx = k;
      if (!ok) idx = 0;
      if (m_chg || ce) begin
        m_ivl = 0; m_time = 0; m_run = 0; m_origin = 1; m_hold = 1;
        m_prog = idx; m_pat_o = m_pat[idx][0];
      end else if (stop) begin
        m_run = 0;
      end else if (se && !m_run && ok && m_cnt[idx] != 0) begin
        if (m_origin) begin
          m_prog = idx; m_ivl = 0; m_time = 0; m_pat_o = m_pat[idx][0];
        end
        m_run = 1; m_origin = 0; m_hold = 0;
      end else if (m_run && tk) begin
        inc = fast ? ((m_acc == 0) ? 1 : m_acc) : 1;
        if (m_time + inc >= m_dur[m_prog][m_ivl]) begin
          if (m_ivl + 1 < m_cnt[m_prog]) begin
            m_ivl++; m_time = 0; m_pat_o = m_pat[m_prog][m_ivl];
          end else begin
            m_run = 0; m_origin = 1; m_time = m_dur[m_prog][m_ivl];
          end
        end else m_time += inc;
      end
      m_chg = cfg_we;
      if (cfg_we) begin
        case (cfg_kind)
          2'd0: m_dur[cfg_prog][cfg_idx] = int'(cfg_wdata);
          2'd1: m_pat[cfg_prog][cfg_idx] = int'(cfg_wdata[OW-1:0]);
          2'd2: m_cnt[cfg_prog] = (cfg_wdata > NINT) ? NINT : int'(cfg_wdata);
          default: m_acc = int'(cfg_wdata);
        endcase
      end
    end
    #2;
    if (rst_n && !done) begin
      expect_eq({req, " interval"}, int'(ivl), m_ivl);
      expect_eq({req, " elapsed"}, int'(elapsed), m_time);
      expect_eq({req, " pattern"}, int'(pattern), m_pat_o);
      expect_eq({req, " halted R13"}, int'(halted), int'(!m_run || stop));
      expect_eq({req, " blink R13"}, int'(blink), int'(stop || m_hold));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int kind, int prog, int idx, int data);
    @(negedge clk);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_prog = 2'(prog); cfg_idx = 3'(idx); cfg_wdata = TW'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    req = "R1";
    expect_eq("R1 power origin halted", int'(halted), 1);
    expect_eq("R1 power origin blink", int'(blink), 1);
    expect_eq("R1 power origin elapsed", int'(elapsed), 0);

    req = "R12";
    wr(1, 0, 0, 'hA1); wr(0, 0, 0, 5); wr(0, 0, 1, 3); wr(0, 0, 2, 4);
    wr(1, 0, 1, 'hB2); wr(1, 0, 2, 'hC3); wr(2, 0, 0, 3); wr(2, 1, 0, 0);
    wr(0, 2, 0, 2); wr(0, 2, 1, 0); wr(1, 2, 0, 'h11); wr(1, 2, 1, 'h22); wr(2, 2, 0, 2);
    for (int i = 0; i < NINT; i++) begin
      wr(0, 3, i, 1); wr(1, 3, i, 16 + i);
    end
    wr(2, 3, 0, 9);
    wr(3, 0, 0, 3);
    step(2);
    expect_eq("R12 pattern after config clear", int'(pattern), 'hA1);

    req = "R3"; pulse_start(); step(1);
    expect_eq("R3 running after start", int'(halted), 0);
    req = "R8"; step(30);
    req = "R11"; step(40);
    expect_eq("R11 halted at end", int'(halted), 1);
    expect_eq("R11 elapsed equals last duration", int'(elapsed), 4);

    req = "R9"; fast = 1; pulse_start(); step(24); fast = 0;

    req = "R6"; pulse_start(); step(9);
    stop = 1; step(3); pulse_start(); step(4);
    stop = 0; step(3);
    expect_eq("R6 still halted after stop release", int'(halted), 1);
    req = "R4"; pulse_start(); step(12);

    req = "R7"; pulse_clr(); step(4);
    pulse_start(); step(6);
    @(negedge clk); start = 1; clr = 1;
    @(negedge clk); start = 0; clr = 0;
    step(1);
    expect_eq("R7 clear beats start", int'(halted), 1);
    req = "R13"; stop = 1; step(3); stop = 0; step(2);
    req = "R7"; stop = 1; pulse_clr(); stop = 0; step(2);

    req = "R5"; sel = 4'b0011; pulse_start(); step(2);
    expect_eq("R5 refused two bits", int'(halted), 1);
    sel = 4'b0000; pulse_start(); step(2);
    expect_eq("R5 refused no bits", int'(halted), 1);
    sel = 4'b0010; pulse_start(); step(2);
    expect_eq("R5 refused empty program", int'(halted), 1);
    req = "R7"; sel = 4'b0000; pulse_clr(); step(2);
    expect_eq("R7 invalid sel uses program 0", int'(pattern), 'hA1);

    req = "R10"; sel = 4'b0100; pulse_start(); step(20);
    sel = 4'b1000; pulse_start(); step(12);
    req = "R12"; wr(3, 0, 0, 2); step(3);
    expect_eq("R12 write forces clear", int'(halted), 1);
    req = "R10"; pulse_start(); step(40);

    req = "R2"; sel = 4'b0001; pulse_start(); step(14);
    @(negedge clk); retain = 1; rst_n = 0;
    step(3); rst_n = 1; step(1);
    expect_eq("R2 still running after retained power-up", int'(halted), 0);
    step(20);
    @(negedge clk); retain = 0; rst_n = 0;
    step(3); rst_n = 1; step(1);
    req = "R1";
    expect_eq("R1 origin after plain power-up", int'(ivl), 0);
    expect_eq("R1 blink after plain power-up", int'(blink), 1);
    step(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule